// File: doc/BRIEF.md
# DMA Channel Register File and Interrupt Controller

This block is the software-visible control front end of a multi-channel DMA engine. A simple 32-bit register bus decodes into three kinds of register:
- one global register that selects the address mode;
- one register window for each pair of channels;
- three interrupt registers: status, pending and enable.

Each channel is programmed with a 64-bit descriptor address split into high and low words, a length and a block length. Receive channels also carry an enable bit and a bytes-per-row value. The block drives those values to the channel engines as plain outputs.

Channels are numbered from zero. Even numbers are receive channels and odd numbers are transmit channels. Channels 2k and 2k+1 share one 64-byte window at k×0x40. The receive registers sit at the start of the window and the transmit registers begin 0x18 bytes further in.

The engines report a finished descriptor with a one-cycle done pulse. The pulse latches a status bit, which software clears by writing 1 to it. The status bits, masked by the enable bits, form a read-only pending view. The single interrupt line is the OR of that view. A write to a transmit channel's low descriptor-address word also sends a one-cycle start pulse to that channel.

Top module: `dma_csr_front`

## Requirements
- R1: The address-mode register at byte address 0x34 stores bit 0 of the write data and drives `addr32_o`. Its other bits read as zero.
- R2: Channel c belongs to the window at (c/2)×0x40. Even c uses the receive offsets from the window base; odd c uses the transmit offsets. Any offset inside a window whose channel number is NUM_CH or more is unmapped.
- R3: Receive offsets are: descriptor-high +0x00, descriptor-low +0x04, length +0x0C, block length +0x10, enable +0x14 (only bit 0 stored), bytes-per-row +0x30. Transmit offsets are: descriptor-high +0x18, descriptor-low +0x1C, block length +0x24, length +0x2C. Every register reads back what was written. `ch_desc_addr_o[64c +: 64]` is {high, low}, `ch_rx_en_o[c]` is the enable bit and `ch_row_bytes_o[32c +: 32]` is bytes-per-row. For transmit channels the enable and bytes-per-row outputs are zero.
- R4: A write to a transmit channel's descriptor-low register raises `ch_tx_start_o[c]` for exactly the one cycle after the write edge. Writes to receive channels never raise a start bit.
- R5: A done pulse on `ch_done_i[c]` sets bit c of the status register at byte address 0x80000.
- R6: Writing the status register clears each bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R7: If a done pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: The enable register at 0x80008 is read/write over bits NUM_CH-1:0. Bits at NUM_CH and above read as zero.
- R9: The pending register at 0x80004 reads as status AND enable. Writes to it change nothing.
- R10: `irq_o` is high whenever any pending bit is set. It follows the registered state, with no extra delay.
- R11: Read data is registered. `bus_rdata` holds the addressed value in the cycle after `bus_rd` is high and is zero otherwise. Unmapped addresses read zero, and writes to them have no effect.
- R12: Reset (`rst_n` low, asynchronous) clears every register and output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| ch_done_i | input | NUM_CH | One-cycle done pulse per channel |
| irq_o | output | 1 | Interrupt request |
| addr32_o | output | 1 | 32-bit address mode select |
| ch_desc_addr_o | output | NUM_CH*64 | Descriptor address per channel |
| ch_rx_en_o | output | NUM_CH | Receive enable per channel |
| ch_row_bytes_o | output | NUM_CH*32 | Bytes-per-row per channel |
| ch_tx_start_o | output | NUM_CH | One-cycle start pulse per transmit channel |

## Verification
The assertions check the following on every cycle:
- the status bits: a done pulse always leaves its bit set, even against a clear; a clearing write empties the written bits; and the bits stay put when nothing touches them;
- the interrupt line: it rises after an enabled done pulse and drops after the enable mask is zeroed;
- the bus timing: start pulses only follow writes, and read data is zero after any cycle without a read.

The address map itself can only be shown by the bench's scenarios. That covers:
- the window and offset placement of every register, and the odd-channel-count hole;
- the zero read-back of unmapped locations;
- the masking of enable bits above the channel count;
- the read-only behaviour of the pending view.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int DATA_W      = 32;
  localparam int WIN_SHIFT   = 6;          // 0x40-byte window per channel pair
  localparam int ACR_ADDR    = 'h34;
  localparam int ISR_ADDR    = 'h80000;
  localparam int IPR_ADDR    = 'h80004;
  localparam int IER_ADDR    = 'h80008;

  typedef enum logic [2:0] {
    RID_NONE,
    RID_DHI,
    RID_DLO,
    RID_LEN,
    RID_BLK,
    RID_EN,
    RID_BPR
  } reg_id_e;

  typedef struct packed {
    logic    hit;
    logic    tx;
    reg_id_e rid;
  } win_dec_t;

  // Offset inside a pair window -> direction and register
  function automatic win_dec_t decode_win(input logic [WIN_SHIFT-1:0] off);
    win_dec_t d;
    d = '{hit: 1'b1, tx: 1'b0, rid: RID_NONE};
    case (off)
      6'h00: d.rid = RID_DHI;
      6'h04: d.rid = RID_DLO;
      6'h0C: d.rid = RID_LEN;
      6'h10: d.rid = RID_BLK;
      6'h14: d.rid = RID_EN;
      6'h30: d.rid = RID_BPR;
      6'h18: begin d.tx = 1'b1; d.rid = RID_DHI; end
      6'h1C: begin d.tx = 1'b1; d.rid = RID_DLO; end
      6'h24: begin d.tx = 1'b1; d.rid = RID_BLK; end
      6'h2C: begin d.tx = 1'b1; d.rid = RID_LEN; end
      default: d.hit = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] ch_sel,
  output reg_id_e           rid,
  output logic              acr_sel,
  output logic              isr_sel,
  output logic              ipr_sel,
  output logic              ier_sel
);

  localparam int PAIR_W = ADDR_W - WIN_SHIFT;

  win_dec_t          dec;
  logic [PAIR_W-1:0] pair;

  always_comb begin
    dec  = decode_win(addr[WIN_SHIFT-1:0]);
    pair = addr[ADDR_W-1:WIN_SHIFT];
    rid  = dec.hit ? dec.rid : RID_NONE;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    localparam logic [PAIR_W-1:0] PAIR_IDX = PAIR_W'(c / 2);
    localparam logic              IS_TX    = 1'((c % 2) == 1);
    assign ch_sel[c] = dec.hit && (pair == PAIR_IDX) && (dec.tx == IS_TX);
  end

  assign acr_sel = (addr == ADDR_W'(ACR_ADDR));
  assign isr_sel = (addr == ADDR_W'(ISR_ADDR));
  assign ipr_sel = (addr == ADDR_W'(IPR_ADDR));
  assign ier_sel = (addr == ADDR_W'(IER_ADDR));

endmodule

// File: rtl/dma_csr_chan_regs.sv
module dma_csr_chan_regs
  import dma_csr_pkg::*;
#(
  parameter bit IS_TX = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  reg_id_e           rid,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val,
  output logic [63:0]       desc_addr,
  output logic              rx_en,
  output logic [DATA_W-1:0] row_bytes,
  output logic              start
);

  logic [DATA_W-1:0] dhi_q, dlo_q, len_q, blk_q;
  logic              start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dhi_q   <= '0;
      dlo_q   <= '0;
      len_q   <= '0;
      blk_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= IS_TX && wr_hit && (rid == RID_DLO);
      if (wr_hit) begin
        case (rid)
          RID_DHI: dhi_q <= wdata;
          RID_DLO: dlo_q <= wdata;
          RID_LEN: len_q <= wdata;
          RID_BLK: blk_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  // Receive-only controls
  logic              en_q;
  logic [DATA_W-1:0] bpr_q;

  if (IS_TX) begin : g_tx
    assign en_q  = 1'b0;
    assign bpr_q = '0;
  end else begin : g_rx
    logic              en_r;
    logic [DATA_W-1:0] bpr_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_r  <= 1'b0;
        bpr_r <= '0;
      end else if (wr_hit) begin
        if (rid == RID_EN)  en_r  <= wdata[0];
        if (rid == RID_BPR) bpr_r <= wdata;
      end
    end
    assign en_q  = en_r;
    assign bpr_q = bpr_r;
  end

  always_comb begin
    case (rid)
      RID_DHI: rd_val = dhi_q;
      RID_DLO: rd_val = dlo_q;
      RID_LEN: rd_val = len_q;
      RID_BLK: rd_val = blk_q;
      RID_EN:  rd_val = {{(DATA_W-1){1'b0}}, en_q};
      RID_BPR: rd_val = bpr_q;
      default: rd_val = '0;
    endcase
  end

  assign desc_addr = {dhi_q, dlo_q};
  assign rx_en     = en_q;
  assign row_bytes = bpr_q;
  assign start     = start_q;

endmodule

// File: rtl/dma_csr_irq.sv
module dma_csr_irq
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] done,
  input  logic              isr_wr,
  input  logic              ier_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CH-1:0] sts,
  output logic [NUM_CH-1:0] ena,
  output logic [NUM_CH-1:0] pend,
  output logic              irq
);

  logic [NUM_CH-1:0] sts_q, ena_q, clr;

  assign clr = isr_wr ? wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      ena_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | done;   // a new event outranks a clear
      if (ier_wr) ena_q <= wdata[NUM_CH-1:0];
    end
  end

  assign sts  = sts_q;
  assign ena  = ena_q;
  assign pend = sts_q & ena_q;
  assign irq  = |pend;

endmodule

// File: rtl/dma_csr_front.sv
module dma_csr_front
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_CH-1:0]    ch_done_i,
  output logic                 irq_o,
  output logic                 addr32_o,
  output logic [NUM_CH*64-1:0] ch_desc_addr_o,
  output logic [NUM_CH-1:0]    ch_rx_en_o,
  output logic [NUM_CH*32-1:0] ch_row_bytes_o,
  output logic [NUM_CH-1:0]    ch_tx_start_o
);

  localparam int EXT_W = DATA_W - NUM_CH;

  logic [NUM_CH-1:0] ch_sel;
  reg_id_e           rid;
  logic              acr_sel, isr_sel, ipr_sel, ier_sel;

  dma_csr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .ch_sel  (ch_sel),
    .rid     (rid),
    .acr_sel (acr_sel),
    .isr_sel (isr_sel),
    .ipr_sel (ipr_sel),
    .ier_sel (ier_sel)
  );

  logic [NUM_CH-1:0] sts_w, ena_w, pend_w;

  dma_csr_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (ch_done_i),
    .isr_wr (bus_wr && isr_sel),
    .ier_wr (bus_wr && ier_sel),
    .wdata  (bus_wdata),
    .sts    (sts_w),
    .ena    (ena_w),
    .pend   (pend_w),
    .irq    (irq_o)
  );

  logic [DATA_W-1:0] ch_rd [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_csr_chan_regs #(.IS_TX((c % 2) == 1)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (bus_wr && ch_sel[c]),
      .rid       (rid),
      .wdata     (bus_wdata),
      .rd_val    (ch_rd[c]),
      .desc_addr (ch_desc_addr_o[c*64 +: 64]),
      .rx_en     (ch_rx_en_o[c]),
      .row_bytes (ch_row_bytes_o[c*32 +: 32]),
      .start     (ch_tx_start_o[c])
    );
  end

  logic acr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 acr_q <= 1'b0;
    else if (bus_wr && acr_sel) acr_q <= bus_wdata[0];
  end

  assign addr32_o = acr_q;

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (acr_sel) rd_mux = {{(DATA_W-1){1'b0}}, acr_q};
    if (isr_sel) rd_mux = {{EXT_W{1'b0}}, sts_w};
    if (ipr_sel) rd_mux = {{EXT_W{1'b0}}, pend_w};
    if (ier_sel) rd_mux = {{EXT_W{1'b0}}, ena_w};
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel[c]) rd_mux = rd_mux | ch_rd[c];
    end
  end

  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= bus_rd ? rd_mux : '0;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/dma_csr_front_chk.sv
module dma_csr_front_chk
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] ch_done_i,
  input logic              irq_o,
  input logic [NUM_CH-1:0] ch_tx_start_o,
  input logic [NUM_CH-1:0] sts,
  input logic [NUM_CH-1:0] ena
);

  logic isr_w, ier_w;
  assign isr_w = bus_wr && (bus_addr == ADDR_W'(ISR_ADDR));
  assign ier_w = bus_wr && (bus_addr == ADDR_W'(IER_ADDR));

  // R5 / R7: a done pulse always leaves its bit set
  p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_done_i != '0) |=> ((sts & $past(ch_done_i)) == $past(ch_done_i)));

  p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_w && ((ch_done_i & bus_wdata[NUM_CH-1:0]) != '0))
      |=> ((sts & $past(ch_done_i)) == $past(ch_done_i)));

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_w && (ch_done_i == '0)) |=> ((sts & $past(bus_wdata[NUM_CH-1:0])) == '0));

  p_sts_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!isr_w && (ch_done_i == '0)) |=> $stable(sts));

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (((ch_done_i & ena) != '0) && !ier_w) |=> irq_o);

  p_irq_mask_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_w && (bus_wdata[NUM_CH-1:0] == '0)) |=> !irq_o);

  p_start_after_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_tx_start_o != '0) |-> $past(bus_wr));

  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> (bus_rdata == '0));

endmodule

bind dma_csr_front dma_csr_front_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_rdata     (bus_rdata),
  .ch_done_i     (ch_done_i),
  .irq_o         (irq_o),
  .ch_tx_start_o (ch_tx_start_o),
  .sts           (sts_w),
  .ena           (ena_w)
);

// File: tb/dma_csr_front_tb_top.sv
`timescale 1ns/1ps
module dma_csr_front_tb_top;

  localparam int NCH = 5;
  localparam int AW  = 20;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [AW-1:0]   bus_addr;
  logic [31:0]     bus_wdata;
  logic            bus_wr, bus_rd;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  ch_done_i;
  logic            irq_o, addr32_o;
  logic [NCH*64-1:0] ch_desc_addr_o;
  logic [NCH-1:0]  ch_rx_en_o;
  logic [NCH*32-1:0] ch_row_bytes_o;
  logic [NCH-1:0]  ch_tx_start_o;

  always #10 clk = ~clk;   // 50 MHz

  dma_csr_front #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (.*);

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic pulse_done(input logic [NCH-1:0] m);
    @(negedge clk);
    ch_done_i = m;
    @(negedge clk);
    ch_done_i = '0;
  endtask

  task automatic t_reset();
    check("R12 irq", irq_o, 0);
    check("R12 addr32", addr32_o, 0);
    check("R12 desc", ch_desc_addr_o[127:0], 0);
    check("R12 start", ch_tx_start_o, 0);
    read_check("R12 status", 'h80000, 0);
    read_check("R12 ch0 dlo", 'h04, 0);
  endtask

  task automatic t_mode();
    bus_write('h34, 32'hFFFF_FFFF);
    check("R1 addr32 set", addr32_o, 1);
    read_check("R1 readback", 'h34, 32'h1);
    @(negedge clk);
    check("R11 rdata idle zero", bus_rdata, 0);
  endtask

  task automatic t_rx_chan();
    // channel 2: pair 1, base 0x40
    bus_write('h40, 32'h1234_5678);
    bus_write('h44, 32'hCAFE_0010);
    bus_write('h4C, 32'h0000_0400);
    bus_write('h50, 32'h0000_0100);
    bus_write('h54, 32'hFFFF_FFFF);
    bus_write('h70, 32'h0000_0280);
    check("R3 rx desc addr", ch_desc_addr_o[2*64 +: 64], 64'h1234_5678_CAFE_0010);
    check("R3 rx enable", ch_rx_en_o, 5'b00100);
    check("R3 rx row bytes", ch_row_bytes_o[2*32 +: 32], 32'h280);
    check("R4 no start on rx", ch_tx_start_o, 0);
    read_check("R3 rx len", 'h4C, 32'h400);
    read_check("R3 rx blk", 'h50, 32'h100);
    read_check("R3 rx en bit0 only", 'h54, 32'h1);
    read_check("R2 ch0 untouched", 'h04, 0);
  endtask

  task automatic t_tx_chan();
    // channel 3: pair 1, transmit at 0x58
    bus_write('h58, 32'h0000_00AB);
    bus_write('h64, 32'h0000_0020);
    bus_write('h6C, 32'h0000_0040);
    check("R4 no start on dhi", ch_tx_start_o, 0);
    bus_write('h5C, 32'h8000_1000);
    check("R4 start pulse", ch_tx_start_o, 5'b01000);
    check("R3 tx desc addr", ch_desc_addr_o[3*64 +: 64], 64'h0000_00AB_8000_1000);
    @(negedge clk);
    check("R4 pulse one cycle", ch_tx_start_o, 0);
    read_check("R3 tx blk", 'h64, 32'h20);
    read_check("R3 tx len", 'h6C, 32'h40);
    check("R3 tx no row bytes", ch_row_bytes_o[3*32 +: 32], 0);
    check("R2 ch2 desc kept", ch_desc_addr_o[2*64 +: 64], 64'h1234_5678_CAFE_0010);
    // channel 1: pair 0 transmit low word at 0x1C
    bus_write('h1C, 32'h0000_0555);
    check("R2 ch1 start", ch_tx_start_o, 5'b00010);
  endtask

  task automatic t_unmapped();
    // channel 5 would be pair 2 transmit; NCH=5 leaves it unmapped
    bus_write('h98, 32'hDEAD_BEEF);
    check("R11 no start unmapped", ch_tx_start_o, 0);
    read_check("R11 read ch5 slot", 'h98, 0);
    read_check("R11 read 0x74", 'h74, 0);
    read_check("R11 read 0x08", 'h08, 0);
    read_check("R11 read 0x80010", 'h80010, 0);
    bus_write('h84, 32'h0000_0077);   // channel 4 rx low word, mapped
    check("R2 ch4 mapped", ch_desc_addr_o[4*64 +: 64], 64'h77);
  endtask

  task automatic t_irq();
    pulse_done(5'b01010);
    check("R10 irq masked", irq_o, 0);
    read_check("R5 status set", 'h80000, 32'h0A);
    bus_write('h80008, 32'h0000_0008);
    check("R10 irq on", irq_o, 1);
    read_check("R9 pending", 'h80004, 32'h08);
    bus_write('h80000, 32'h0000_0002);
    read_check("R6 clear one bit", 'h80000, 32'h08);
    check("R10 irq still on", irq_o, 1);
    bus_write('h80000, 32'h0000_0008);
    read_check("R6 clear last", 'h80000, 0);
    check("R10 irq off", irq_o, 0);
  endtask

  task automatic t_set_wins();
    pulse_done(5'b11111);
    @(negedge clk);
    bus_addr = 'h80000; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1; ch_done_i = 5'b00100;
    @(negedge clk);
    bus_wr = 1'b0; ch_done_i = '0;
    read_check("R7 set wins", 'h80000, 32'h04);
    bus_write('h80008, 32'hFFFF_FFFF);
    read_check("R8 enable masked", 'h80008, 32'h1F);
    bus_write('h80004, 32'hFFFF_FFFF);
    read_check("R9 pending read-only", 'h80004, 32'h04);
    read_check("R9 status unchanged", 'h80000, 32'h04);
    bus_write('h80008, 32'h0);
    check("R10 irq off after mask", irq_o, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0; ch_done_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_rx_chan();
    t_tx_chan();
    t_unmapped();
    t_irq();
    t_set_wins();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule